// File: doc/BRIEF.md
# Triple Match Timer

This peripheral holds three independent 32-bit timers behind a small word-addressed register port. Each timer owns a live counter, a reload value and two comparison values. A timer counts up or down by one on every tick it receives. When the counter reaches the end of its range it reloads from its reload value instead of stepping. Ticks come from the core clock or from a sampled external tick input. Only enabled timers receive ticks.

Comparator hits and wraps are recorded in a shared sticky event register. A shared mask register selects which recorded events may reach the interrupt line of their timer. A per-timer interrupt-enable bit in the control register then gates that line. Software can read the counter at any time and can write it at any time. A typical setup uses one timer as a free-running time base and another as an event timer, for periodic or one-shot operation.

Top module: `tri_match_timer`

## Requirements
- R1: After synchronous reset every register reads zero and all interrupt outputs are low. With all registers at zero, every timer is stopped and set to count down.
- R2: Timer n (n = 0..2) has four word registers at byte address 16n. In offset order they are counter (+0), reload (+4), compare A (+8) and compare B (+12). Control is at 0x30, event status at 0x34 and event mask at 0x38. Unused upper bits and unmapped addresses read as zero.
- R3: With its direction bit clear, a ticked timer decrements. A tick that finds the counter at zero loads the reload value instead, so the period is reload+1 ticks. That reload raises the timer's wrap event.
- R4: With its direction bit set, a ticked timer increments. A tick that finds the counter at 0xFFFFFFFF loads the reload value and raises the wrap event. A reload value of 0xFFFFFFFF-(P-1) therefore gives a wrap every P ticks.
- R5: Control bit 3n enables timer n and bit 3n+1 picks its tick source. With source 0 the timer advances every clock cycle. With source 1 it advances in each cycle after one in which ext_tick was sampled high. A timer without ticks holds its counter.
- R6: The tick that makes the counter equal to compare A raises event bit 3n. The tick that makes it equal to compare B raises event bit 3n+1. The wrap event is bit 3n+2. These hold in both directions.
- R7: Event bits are sticky. A write to the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. An event arriving in the same cycle as a clear keeps its bit set.
- R8: irq[n] is the OR of status bits 3n..3n+2, each ANDed with its mask bit, and then ANDed with control bit 3n+2. A mask bit of 1 lets the event through.
- R9: A write to a counter register loads the written value at that edge. It takes priority over a tick in the same cycle, and that tick raises no event.
- R10: Control bits 9, 10 and 11 set the count direction for timers 0, 1 and 2. A value of 1 means up and 0 means down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External tick, sampled once per clock |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte address; reads are combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 3 | One interrupt line per timer |

## Verification
The bench drives a down-counting timer across zero and checks that the count resumes from the reload value. A design that wrapped to all ones, or that skipped the zero count, would end on a different counter value and show no wrap event. An up-counting timer is run across 0xFFFFFFFF to check the reload and the wrap event. The external tick source is checked for the one-cycle sampling delay and for holding the count while the input is idle. Status clears are timed to land on the same edge as a compare hit and as a counter write, which catches a clear that beats a new event and a tick that overrides software. Finally, the mask and interrupt-enable bits are combined in different patterns to catch gating on the wrong timer or the wrong bit.

// File: rtl/tmt_pkg.sv
package tmt_pkg;

    // Register slot inside one timer's 16-byte window; the order is the address order.
    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CMP_A  = 2'd2,
        REG_CMP_B  = 2'd3
    } tmr_reg_e;

    // Per-timer event group; bit 0 compare A, bit 1 compare B, bit 2 wrap.
    typedef struct packed {
        logic wrap;
        logic hit_b;
        logic hit_a;
    } tmr_evt_t;

    // Per-timer view of the shared control word.
    typedef struct packed {
        logic count_up;
        logic irq_en;
        logic ext_src;
        logic enable;
    } tmr_cfg_t;

    localparam int EVT_PER_TMR   = 3;
    localparam int WIN_BYTES     = 16;
    localparam int STATUS_OFFSET = 4;
    localparam int MASK_OFFSET   = 8;

    // Pull timer idx's settings out of the control word.
    // Three bits per timer at 3*idx, direction bits packed after all groups.
    function automatic tmr_cfg_t cfg_of(input logic [31:0] ctrl, input int idx, input int num);
        tmr_cfg_t c;
        c.enable   = ctrl[EVT_PER_TMR*idx];
        c.ext_src  = ctrl[EVT_PER_TMR*idx + 1];
        c.irq_en   = ctrl[EVT_PER_TMR*idx + 2];
        c.count_up = ctrl[EVT_PER_TMR*num + idx];
        return c;
    endfunction

endpackage

// File: rtl/tmt_tick_src.sv
module tmt_tick_src #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ext_tick,
    input  logic [NUM-1:0] enable,
    input  logic [NUM-1:0] ext_src,
    output logic [NUM-1:0] tick
);
    // One sampling flop for the external tick, shared by all timers.
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_tick;
    end

    for (genvar n = 0; n < NUM; n++) begin : g_sel
        assign tick[n] = enable[n] & (ext_src[n] ? ext_q : 1'b1);
    end

    // R5: a timer on the external source sees no tick unless the input was high one edge earlier
    AST_EXT_DELAY: assert property (@(posedge clk) disable iff (rst)
        (!ext_tick) |=> ((tick & ext_src) == '0)); // R5
endmodule

// File: rtl/tmt_channel.sv
module tmt_channel
    import tmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         count_up,
    input  logic         wr_en,
    input  tmr_reg_e     reg_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output tmr_evt_t     evt
);
    localparam logic [W-1:0] CNT_TOP  = '1;
    localparam logic [W-1:0] CNT_ZERO = '0;
    localparam logic [W-1:0] CNT_ONE  = W'(1);

    logic [W-1:0] cnt_q, reload_q, cmp_a_q, cmp_b_q;
    logic [W-1:0] stepped, cnt_next;
    logic         wr_cnt, wr_reload, wr_cmp_a, wr_cmp_b;
    logic         at_end, advance;

    assign wr_cnt    = wr_en && (reg_sel == REG_COUNT);
    assign wr_reload = wr_en && (reg_sel == REG_RELOAD);
    assign wr_cmp_a  = wr_en && (reg_sel == REG_CMP_A);
    assign wr_cmp_b  = wr_en && (reg_sel == REG_CMP_B);

    // End of range depends on direction; reaching it loads the reload value.
    assign at_end   = count_up ? (cnt_q == CNT_TOP) : (cnt_q == CNT_ZERO);
    assign stepped  = count_up ? (cnt_q + CNT_ONE) : (cnt_q - CNT_ONE);
    assign cnt_next = at_end ? reload_q : stepped;

    // A software counter write wins over the tick and suppresses its events.
    assign advance   = tick && !wr_cnt;
    assign evt.hit_a = advance && (cnt_next == cmp_a_q);
    assign evt.hit_b = advance && (cnt_next == cmp_b_q);
    assign evt.wrap  = advance && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            cmp_a_q  <= '0;
            cmp_b_q  <= '0;
        end else begin
            if (wr_cnt)         cnt_q <= wr_data;
            else if (tick)      cnt_q <= cnt_next;
            if (wr_reload)      reload_q <= wr_data;
            if (wr_cmp_a)       cmp_a_q  <= wr_data;
            if (wr_cmp_b)       cmp_b_q  <= wr_data;
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_COUNT:  rd_data = cnt_q;
            REG_RELOAD: rd_data = reload_q;
            REG_CMP_A:  rd_data = cmp_a_q;
            default:    rd_data = cmp_b_q;
        endcase
    end

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !count_up && !wr_cnt && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R3
    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !count_up && !wr_cnt && cnt_q == CNT_ZERO) |=> (cnt_q == $past(reload_q))); // R3
    AST_UP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && count_up && !wr_cnt && cnt_q == CNT_TOP) |=> (cnt_q == $past(reload_q))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_cnt) |=> $stable(cnt_q)); // R5
    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt_q == $past(wr_data))); // R9
endmodule

// File: rtl/tmt_irq_status.sv
module tmt_irq_status #(
    parameter int NUM   = 3,
    parameter int EVT_W = 3 * NUM
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic             wr_status,
    input  logic             wr_mask,
    input  logic [EVT_W-1:0] wr_data,
    input  logic [NUM-1:0]   irq_en,
    output logic [EVT_W-1:0] status_q,
    output logic [EVT_W-1:0] mask_q,
    output logic [NUM-1:0]   irq
);
    logic [EVT_W-1:0] kept;
    logic [EVT_W-1:0] live;

    // Write-zero-to-clear, then new events OR in so they win over the clear.
    assign kept = wr_status ? (status_q & wr_data) : status_q;
    assign live = status_q & mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= kept | evt;
            if (wr_mask) mask_q <= wr_data;
        end
    end

    for (genvar n = 0; n < NUM; n++) begin : g_irq
        assign irq[n] = irq_en[n] & (|live[3*n +: 3]);
    end

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status_q & $past(evt)) == $past(evt))); // R7
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_status && evt == '0) |=> $stable(status_q)); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        ((irq & ~irq_en) == '0)); // R8
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
    import tmt_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int TMR_W      = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ext_tick,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [TMR_W-1:0]      bus_wdata,
    output logic [TMR_W-1:0]      bus_rdata,
    output logic [NUM_TIMERS-1:0] irq
);
    localparam int EVT_W  = EVT_PER_TMR * NUM_TIMERS;
    localparam int CTRL_W = 4 * NUM_TIMERS;
    localparam int IDX_W  = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_TIMERS * WIN_BYTES);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_TIMERS * WIN_BYTES + STATUS_OFFSET);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_TIMERS * WIN_BYTES + MASK_OFFSET);

    logic [CTRL_W-1:0]     ctrl_q;
    tmr_cfg_t              cfg      [NUM_TIMERS];
    logic [TMR_W-1:0]      chan_rd  [NUM_TIMERS];
    tmr_evt_t              chan_evt [NUM_TIMERS];
    logic [NUM_TIMERS-1:0] en_v, src_v, ie_v, tick_v;
    logic [EVT_W-1:0]      evt_v, status_v, mask_v;
    logic                  hit_tmr, wr_ctrl, wr_stat, wr_mask;
    logic [IDX_W-1:0]      tmr_idx;
    tmr_reg_e              reg_sel;
    logic                  unused_bits;

    assign hit_tmr = bus_addr < CTRL_ADDR;
    assign tmr_idx = bus_addr[ADDR_W-1:4];
    assign reg_sel = tmr_reg_e'(bus_addr[3:2]);
    assign wr_ctrl = bus_wr && (bus_addr == CTRL_ADDR);
    assign wr_stat = bus_wr && (bus_addr == STAT_ADDR);
    assign wr_mask = bus_wr && (bus_addr == MASK_ADDR);
    assign unused_bits = ^{bus_wdata[TMR_W-1:CTRL_W], bus_addr[1:0]};

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_tmr
        assign cfg[n]   = cfg_of(32'(ctrl_q), n, NUM_TIMERS);
        assign en_v[n]  = cfg[n].enable;
        assign src_v[n] = cfg[n].ext_src;
        assign ie_v[n]  = cfg[n].irq_en;

        tmt_channel #(.W(TMR_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_v[n]),
            .count_up (cfg[n].count_up),
            .wr_en    (bus_wr && hit_tmr && (tmr_idx == IDX_W'(n))),
            .reg_sel  (reg_sel),
            .wr_data  (bus_wdata),
            .rd_data  (chan_rd[n]),
            .evt      (chan_evt[n])
        );

        assign evt_v[EVT_PER_TMR*n +: EVT_PER_TMR] = chan_evt[n];
    end

    tmt_tick_src #(.NUM(NUM_TIMERS)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .ext_tick (ext_tick),
        .enable   (en_v),
        .ext_src  (src_v),
        .tick     (tick_v)
    );

    tmt_irq_status #(.NUM(NUM_TIMERS), .EVT_W(EVT_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt_v),
        .wr_status (wr_stat),
        .wr_mask   (wr_mask),
        .wr_data   (bus_wdata[EVT_W-1:0]),
        .irq_en    (ie_v),
        .status_q  (status_v),
        .mask_q    (mask_v),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_tmr) begin
            for (int n = 0; n < NUM_TIMERS; n++) begin
                if (tmr_idx == IDX_W'(n)) bus_rdata = chan_rd[n];
            end
        end else if (bus_addr == CTRL_ADDR) begin
            bus_rdata = TMR_W'(ctrl_q);
        end else if (bus_addr == STAT_ADDR) begin
            bus_rdata = TMR_W'(status_v);
        end else if (bus_addr == MASK_ADDR) begin
            bus_rdata = TMR_W'(mask_v);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0)); // R1
endmodule

// File: tb/tri_match_timer_bench.sv
module tri_match_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ext_tick;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    typedef struct {
        logic        is_irq;
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_match_timer u_tri_match_timer (
        .clk       (clk),
        .rst       (rst),
        .ext_tick  (ext_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Monitor: pops one expectation per cycle, compares away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {29'd0, irq} : bus_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                         it.tag, it.addr, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        step();
        bus_wr    = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        bus_addr  = a;
        it.is_irq = 1'b0;
        it.addr   = a;
        it.exp    = e;
        it.tag    = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic chk_irq(input logic [2:0] e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b1;
        it.addr   = bus_addr;
        it.exp    = {29'd0, e};
        it.tag    = tag;
        sb_q.push_back(it);
        step();
    endtask

    initial begin
        rst = 1'b1; ext_tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk_rd(8'h30, 32'h0, "R1 control");
        chk_rd(8'h34, 32'h0, "R1 status");
        chk_rd(8'h00, 32'h0, "R1 counter0");
        chk_irq(3'b000, "R1 irq");

        // Timer 0 counting down across zero (R3, R6)
        wr(8'h04, 32'd3);
        wr(8'h08, 32'd2);
        wr(8'h0C, 32'd100);
        wr(8'h00, 32'd5);
        chk_rd(8'h04, 32'd3, "R2 reload readback");
        wr(8'h30, 32'h1);       // enable timer 0, down, core clock
        idle(7);
        wr(8'h30, 32'h0);       // 8 ticks: 5,4,3,2,1,0 -> 3,2,1
        chk_rd(8'h00, 32'd1, "R3 down count with reload");
        chk_rd(8'h34, 32'h5, "R6 compare A and wrap events");
        idle(3);
        chk_rd(8'h00, 32'd1, "R5 disabled timer holds");

        // Mask and interrupt enable (R8, R7)
        wr(8'h38, 32'h1FF);
        chk_rd(8'h38, 32'h1FF, "R2 mask readback");
        chk_irq(3'b000, "R8 irq enable off");
        wr(8'h30, 32'h4);
        chk_irq(3'b001, "R8 irq timer0");
        wr(8'h34, 32'hFFFF_FFFE);
        chk_rd(8'h34, 32'h4, "R7 clear only zero bits");
        chk_irq(3'b001, "R8 irq from wrap");
        wr(8'h34, 32'h0);
        chk_rd(8'h34, 32'h0, "R7 clear all");
        chk_irq(3'b000, "R8 irq after clear");

        // Timer 1 counting up with period 4 (R4, R10)
        wr(8'h30, 32'h0);
        wr(8'h38, 32'h0);
        wr(8'h14, 32'hFFFF_FFFC);
        wr(8'h10, 32'hFFFF_FFFC);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0);
        wr(8'h30, 32'h408);     // enable timer 1, up
        idle(5);
        wr(8'h30, 32'h0);       // 6 ticks: FD,FE,FF -> FC,FD,FE
        chk_rd(8'h10, 32'hFFFF_FFFE, "R4 up count with reload");
        chk_rd(8'h34, 32'h28, "R4 wrap and R6 compare A on timer1");
        chk_rd(8'h00, 32'd1, "R5 timer0 untouched");
        wr(8'h38, 32'h008);
        wr(8'h30, 32'h020);
        chk_irq(3'b010, "R8 masked irq timer1");
        wr(8'h38, 32'h001);
        chk_irq(3'b000, "R8 mask blocks events");
        wr(8'h30, 32'h0);
        wr(8'h34, 32'h0);

        // Timer 2 on the external tick (R5)
        wr(8'h20, 32'd10);
        wr(8'h30, 32'h0C0);
        idle(5);
        chk_rd(8'h20, 32'd10, "R5 idle external tick holds");
        ext_tick = 1'b1;
        idle(3);
        ext_tick = 1'b0;
        idle(4);
        wr(8'h30, 32'h0);
        chk_rd(8'h20, 32'd7, "R5 three external ticks");
        chk_rd(8'h34, 32'h0, "R6 no stray events");

        // Event wins over a clear in the same cycle (R7)
        wr(8'h00, 32'd0);
        wr(8'h34, 32'h0);
        wr(8'h30, 32'h201);     // timer 0 up
        wr(8'h34, 32'h0);       // tick -> 1
        wr(8'h34, 32'h0);       // tick -> 2, compare A hit
        wr(8'h30, 32'h0);       // tick -> 3
        chk_rd(8'h34, 32'h1, "R7 event beats clear");
        chk_rd(8'h00, 32'd3, "R10 timer0 counts up");

        // Counter write beats the tick (R9)
        wr(8'h34, 32'h0);
        wr(8'h30, 32'h201);
        wr(8'h00, 32'h100);
        wr(8'h30, 32'h0);
        chk_rd(8'h00, 32'h101, "R9 write overrides tick");

        // Decode edges (R2)
        chk_rd(8'h3C, 32'h0, "R2 unmapped word");
        chk_rd(8'h40, 32'h0, "R2 beyond map");
        wr(8'h30, 32'hFFFF_FFFF);
        chk_rd(8'h30, 32'hFFF, "R2 control width");
        wr(8'h30, 32'h0);

        idle(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule